// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block keeps the program counter of a small accumulator machine and works out the address of the next instruction on every clock. One adder serves both plain sequencing and conditional skipping. Its second addend is one plus a condition flag, so a taken skip moves the counter by two and an untaken skip moves it by one.

A jump loads a 7-bit target straight into the counter. When neither an advance nor a jump is requested, the counter keeps its value. All arithmetic wraps within the 128-entry instruction space. The sequencer drives the advance strobe, the jump strobe and the two skip selects. The execution stage supplies the carry and zero flags.

Top module: `pc_nextaddr`

## Requirements
- R1: A synchronous active-high reset `rst` sets `pc` to 0 at the next rising clock edge.
- R2: With `advance`=1, `jump`=0 and both skip selects 0, `pc` becomes `pc`+1 at the next edge.
- R3: With `advance`=1 and `skip_on_c`=1, `pc` becomes `pc`+1+`flag_c` at the next edge.
- R4: With `advance`=1 and `skip_on_z`=1, `pc` becomes `pc`+1+`flag_z` at the next edge.
- R5: With `jump`=1, `pc` becomes `target` at the next edge, whatever the values of `advance`, the skip selects and the flags.
- R6: With `advance`=0 and `jump`=0, `pc` keeps its value. Skip selects and flags have no effect in this case.
- R7: All `pc` arithmetic wraps modulo 128, so 127+1 gives 0 and 127+2 gives 1.
- R8: If both skip selects are 1 while advancing, the added flag is the OR of `flag_c` and `flag_z`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| advance | input | 1 | Request a sequential or skip update |
| jump | input | 1 | Load `target` into the counter |
| target | input | 7 | Jump destination |
| skip_on_c | input | 1 | Add `flag_c` to the increment |
| skip_on_z | input | 1 | Add `flag_z` to the increment |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| pc | output | 7 | Current program counter |

## Verification
The hardest case to reach is a taken skip at the top of the address space, where 127 plus two must land on 1. A jump to 126 or 127 sets this up. Skips with the flag set and the flag clear then follow. Random stimulus also mixes jumps with every other request and holds the counter idle while the flags toggle. The behavioural model is compared with `pc` after every edge.

// File: rtl/pc_nextaddr.sv
module pc_nextaddr #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          advance,
  input  logic          jump,
  input  logic [AW-1:0] target,
  input  logic          skip_on_c,
  input  logic          skip_on_z,
  input  logic          flag_c,
  input  logic          flag_z,
  output logic [AW-1:0] pc
);
  logic          extra;
  logic [AW-1:0] sum;

  assign extra = (skip_on_c & flag_c) | (skip_on_z & flag_z);
  assign sum   = pc + AW'(1) + AW'(extra);

  always_ff @(posedge clk) begin
    if (rst)          pc <= '0;
    else if (jump)    pc <= target;
    else if (advance) pc <= sum;
  end
endmodule

module pc_nextaddr_chk #(
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          advance,
  input logic          jump,
  input logic [AW-1:0] target,
  input logic          skip_on_c,
  input logic          skip_on_z,
  input logic          flag_c,
  input logic          flag_z,
  input logic [AW-1:0] pc
);
  logic live;
  always_ff @(posedge clk) live <= !rst;

  assert_reset_zero_R1: assert property (@(posedge clk) rst |=> pc == '0);
  assert_jump_loads_R5: assert property (@(posedge clk) disable iff (rst)
    jump |=> pc == $past(target));
  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (live && !jump && !advance) |=> $stable(pc));
  assert_step_plain_R2: assert property (@(posedge clk) disable iff (rst)
    (!jump && advance && !skip_on_c && !skip_on_z) |=> pc == AW'($past(pc) + 1));
  assert_skip_c_R3: assert property (@(posedge clk) disable iff (rst)
    (!jump && advance && skip_on_c && !skip_on_z) |=> pc == AW'($past(pc) + 1 + $past(flag_c)));
  assert_skip_z_R4: assert property (@(posedge clk) disable iff (rst)
    (!jump && advance && skip_on_z && !skip_on_c) |=> pc == AW'($past(pc) + 1 + $past(flag_z)));
  assert_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (!jump && advance && pc == '1) |=> pc <= AW'(1));
endmodule

bind pc_nextaddr pc_nextaddr_chk #(.AW(AW)) u_chk (.*);

// File: tb/pc_nextaddr_bench.sv
module pc_nextaddr_bench;
  logic clk = 0, rst = 1, advance = 0, jump = 0, skip_on_c = 0, skip_on_z = 0;
  logic flag_c = 0, flag_z = 0;
  logic [6:0] target = 0;
  logic [6:0] pc;
  int checks = 0, errors = 0, model = 0, cyc = 0;

  always #2 clk = ~clk;

  pc_nextaddr u_pc_nextaddr (.*);

  task automatic step(input string req);
    int inc;
    @(posedge clk);
    if (rst) model = 0;
    else if (jump) model = target;
    else if (advance) begin
      inc = 1;
      if ((skip_on_c && flag_c) || (skip_on_z && flag_z)) inc = 2;
      model = (model + inc) % 128;
    end
    #1;
    checks++;
    if (pc !== 7'(model)) begin
      errors++;
      $display("FAIL %s pc=%0d expected=%0d", req, pc, model);
    end
  endtask

  task automatic drive(input logic a, j, sc, sz, fc, fz, input int t);
    advance = a; jump = j; skip_on_c = sc; skip_on_z = sz;
    flag_c = fc; flag_z = fz; target = 7'(t);
  endtask

  initial begin
    #1;
    drive(1, 1, 0, 0, 0, 0, 55); step("R1"); step("R1");
    rst = 0;
    drive(1, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) step("R2");
    drive(1, 0, 1, 0, 1, 0, 0); step("R3");
    drive(1, 0, 1, 0, 0, 1, 0); step("R3");
    drive(1, 0, 0, 1, 0, 1, 0); step("R4");
    drive(1, 0, 0, 1, 1, 0, 0); step("R4");
    drive(1, 0, 1, 1, 0, 1, 0); step("R8");
    drive(1, 0, 1, 1, 1, 0, 0); step("R8");
    drive(1, 1, 1, 0, 1, 0, 100); step("R5");
    drive(0, 0, 1, 1, 1, 1, 9); step("R6"); step("R6");
    drive(0, 1, 0, 0, 0, 0, 127); step("R5");
    drive(1, 0, 0, 0, 0, 0, 0); step("R7");
    drive(0, 1, 0, 0, 0, 0, 127); step("R5");
    drive(1, 0, 1, 0, 1, 0, 0); step("R7");
    drive(0, 1, 0, 0, 0, 0, 126); step("R5");
    drive(1, 0, 0, 1, 0, 1, 0); step("R7");
    for (int i = 0; i < 3000; i++) begin
      drive($urandom % 4 != 0, $urandom % 6 == 0, $urandom % 2, $urandom % 2,
            $urandom % 2, $urandom % 2, $urandom % 128);
      step("R2-mix");
    end
    rst = 1; step("R1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog pc=%0d expected=done", pc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule